// File: doc/BRIEF.md
# SPI FIFO status and request controller

This block sits between a serial shift engine and the rest of a chip. It holds a transmit queue and a receive queue, each with its own configurable depth. The host fills the transmit queue and drains the receive queue through plain push/pop strobes. The shift engine takes frames from the transmit side, deposits captured frames on the receive side, and reports the end of each frame. Clock generation, chip-select timing and the shifting itself live elsewhere. To this block the shifter is only a set of strobes.

Around the two queues the block keeps four sticky event flags: frame finished, last frame of a queue, transmit starvation and receive overflow. It also derives two level requests: room in the transmit queue and data in the receive queue. Each event and each request has an enable. The room and data requests can each be steered to a DMA request line instead of the shared interrupt line. A small register port reads and writes the control word, the status word, the enable word and the two queue levels. Through the control word software can halt or run the peripheral, shrink either queue to a single entry, flush either queue with a self-clearing bit, and choose whether a frame arriving at a full receive queue is discarded or replaces the oldest entry.

Top module: `spi_fifo_ctl`

## Requirements
- R1: After reset the peripheral is halted, both queues are empty, all sticky flags and all enables are 0. Register address 0 reads 0x01, address 1 reads 0x08, and addresses 2 and 3 read 0x00.
- R2: Status word at address 1 has these bits: done at bit 0, last-of-queue at bit 1, TX starvation at bit 2, TX room at bit 3, RX overflow at bit 4, RX data at bit 5, running at bit 6, and bit 7 reads 0. Writing 1 to bit 0, 1, 2 or 4 clears that sticky flag; writing 0 leaves it unchanged. An event in the same cycle as its clear leaves the flag set.
- R3: The TX room bit is 1 while the TX queue holds fewer entries than its capacity. The RX data bit is 1 while the RX queue is not empty. Writes to bits 3, 5 and 6 have no effect.
- R4: Enable word at address 2: bits 0 to 5 enable the status bits 0 to 5; bit 6 routes TX room to DMA; bit 7 routes RX data to DMA. `irq` is the OR of every enabled status bit, leaving out TX room when bit 6 is set and RX data when bit 7 is set.
- R5: `dma_tx_req` equals TX room AND enable bit 3 AND enable bit 6. `dma_rx_req` equals RX data AND enable bit 5 AND enable bit 7.
- R6: A shifter pop while running with the TX queue empty sets TX starvation and removes nothing.
- R7: A shifter push while running, to a full RX queue with no host pop in that cycle, sets RX overflow. When control bit 5 is 0 the new frame is dropped. When it is 1 the oldest entry is dropped and the new frame is appended.
- R8: Control bit 1 (TX) and bit 2 (RX) limit the matching queue to a capacity of one entry while set. Entries already held are kept.
- R9: Control bit 3 empties the TX queue and bit 4 empties the RX queue in the write's cycle, overriding any push or pop in that cycle. Both bits always read back 0.
- R10: Control bit 0 is halt; bit 6 of the status word reads its inverse. While halted, shifter pops, pushes and frame-done strobes have no effect, and `sh_tx_valid` is 0.
- R11: A frame-done strobe while running sets done. With `sh_eoq` also high it sets last-of-queue as well.
- R12: Both queues deliver frames in arrival order. On a full queue, a push and an accepted pop in the same cycle are both performed.
- R13: Address 3 reads the RX level in bits 7:4 and the TX level in bits 3:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for write and read |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| host_tx_push | input | 1 | Host appends a frame to the TX queue |
| host_tx_data | input | DATA_W | Frame appended by the host |
| host_rx_pop | input | 1 | Host removes the RX queue head |
| host_rx_data | output | DATA_W | RX queue head |
| sh_pop | input | 1 | Shifter takes the TX queue head |
| sh_tx_valid | output | 1 | Running and TX queue not empty |
| sh_tx_data | output | DATA_W | TX queue head |
| sh_push | input | 1 | Shifter delivers a received frame |
| sh_rx_data | input | DATA_W | Received frame |
| sh_done | input | 1 | Shifter finished a frame |
| sh_eoq | input | 1 | Finished frame was the last of its queue |
| irq | output | 1 | Combined interrupt request |
| dma_tx_req | output | 1 | DMA request for TX room |
| dma_rx_req | output | 1 | DMA request for RX data |

## Verification
The bench targets two collisions. The first is a status clear that lands in the same cycle as the event that sets the flag again. The second is a host pop or a flush that lands in the same cycle as a shifter push into a full receive queue. Directed steps stage each pairing exactly: a starvation pop together with a write of 1 to its bit, and a shifter push together with a host pop on a full queue. A long stretch of random traffic then makes these pairings recur under every mode setting. A behavioural model built on queues predicts the result, and every output is compared against it on every cycle, so the pairing is judged on the status word, the queue levels and the data heads in the cycle that follows.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  localparam int REG_W = 8;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_ENAB = 2'd2;
  localparam logic [1:0] A_LVL  = 2'd3;

  // status word bit positions (also enable bits 0..5)
  localparam int B_DONE  = 0;
  localparam int B_EOQ   = 1;
  localparam int B_UNDER = 2;
  localparam int B_FILL  = 3;
  localparam int B_OVER  = 4;
  localparam int B_DRAIN = 5;
  localparam int B_RUN   = 6;

  // control word bit positions
  localparam int C_HALT  = 0;
  localparam int C_TXOFF = 1;
  localparam int C_RXOFF = 2;
  localparam int C_TXFL  = 3;
  localparam int C_RXFL  = 4;
  localparam int C_KEEP  = 5;

  // enable word routing bits
  localparam int E_FILLDMA  = 6;
  localparam int E_DRAINDMA = 7;

  // sticky flag vector indices
  localparam int NSTICKY  = 4;
  localparam int S_DONE   = 0;
  localparam int S_EOQ    = 1;
  localparam int S_UNDER  = 2;
  localparam int S_OVER   = 3;

  typedef struct packed {
    logic halt;
    logic tx_off;
    logic rx_off;
    logic keep;
  } ctrl_t;
endpackage

// File: rtl/spi_fifo_store.sv
module spi_fifo_store #(
  parameter int W     = 16,
  parameter int DEPTH = 4,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          single,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rptr_q, rptr_d, wptr_q, wptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop, wr_en;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (cnt_q == '0);
  assign full    = single ? (cnt_q != '0) : (cnt_q >= CW'(DEPTH));
  assign do_pop  = pop & ~empty;
  assign do_push = push & (~full | do_pop);
  assign wr_en   = do_push & ~flush;

  always_comb begin
    rptr_d = rptr_q;
    wptr_d = wptr_q;
    cnt_d  = cnt_q;
    if (flush) begin
      rptr_d = '0;
      wptr_d = '0;
      cnt_d  = '0;
    end else begin
      if (do_pop)  rptr_d = bump(rptr_q);
      if (do_push) wptr_d = bump(wptr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_d = cnt_q + CW'(1);
        2'b01:   cnt_d = cnt_q - CW'(1);
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr_q <= '0;
      wptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      rptr_q <= rptr_d;
      wptr_q <= wptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr_q] <= wdata;
  end

  assign head  = mem[rptr_q];
  assign count = cnt_q;
endmodule

// File: rtl/spi_fifo_flags.sv
module spi_fifo_flags #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);
  logic [N-1:0] q_r, q_d;

  for (genvar i = 0; i < N; i++) begin : g_bit
    // a new event outranks a clear arriving in the same cycle
    assign q_d[i] = set[i] | (q_r[i] & ~clr[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_d;
  end

  assign q = q_r;
endmodule

// File: rtl/spi_fifo_route.sv
module spi_fifo_route
  import spi_fifo_pkg::*;
(
  input  logic [NSTICKY-1:0] sticky,
  input  logic               fill,
  input  logic               drain,
  input  logic [REG_W-1:0]   en,
  output logic               irq,
  output logic               dma_tx,
  output logic               dma_rx
);
  logic fill_on, drain_on;

  assign fill_on  = fill  & en[B_FILL];
  assign drain_on = drain & en[B_DRAIN];

  assign dma_tx = fill_on  &  en[E_FILLDMA];
  assign dma_rx = drain_on &  en[E_DRAINDMA];

  assign irq = (sticky[S_DONE]  & en[B_DONE])
             | (sticky[S_EOQ]   & en[B_EOQ])
             | (sticky[S_UNDER] & en[B_UNDER])
             | (sticky[S_OVER]  & en[B_OVER])
             | (fill_on  & ~en[E_FILLDMA])
             | (drain_on & ~en[E_DRAINDMA]);
endmodule

// File: rtl/spi_fifo_ctl.sv
module spi_fifo_ctl
  import spi_fifo_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int TX_DEPTH = 4,
  parameter int RX_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              host_tx_push,
  input  logic [DATA_W-1:0] host_tx_data,
  input  logic              host_rx_pop,
  output logic [DATA_W-1:0] host_rx_data,
  input  logic              sh_pop,
  output logic              sh_tx_valid,
  output logic [DATA_W-1:0] sh_tx_data,
  input  logic              sh_push,
  input  logic [DATA_W-1:0] sh_rx_data,
  input  logic              sh_done,
  input  logic              sh_eoq,
  output logic              irq,
  output logic              dma_tx_req,
  output logic              dma_rx_req
);
  localparam int TX_CW = $clog2(TX_DEPTH + 1);
  localparam int RX_CW = $clog2(RX_DEPTH + 1);

  ctrl_t             ctl_q, ctl_d;
  logic [REG_W-1:0]  en_q, en_d;
  logic              wr_ctrl, wr_stat, wr_enab;
  logic              tx_flush, rx_flush, run;
  logic              tx_full, tx_empty, rx_full, rx_empty;
  logic [TX_CW-1:0]  tx_cnt;
  logic [RX_CW-1:0]  rx_cnt;
  logic              tx_pop, sh_in, host_pop_ok, rx_over_evt, rx_drop_old, rx_pop;
  logic [NSTICKY-1:0] ev_set, ev_clr, sticky_q;
  logic              fill, drain;
  logic [REG_W-1:0]  stat_word;

  assign wr_ctrl  = reg_wr & (reg_addr == A_CTRL);
  assign wr_stat  = reg_wr & (reg_addr == A_STAT);
  assign wr_enab  = reg_wr & (reg_addr == A_ENAB);
  assign tx_flush = wr_ctrl & reg_wdata[C_TXFL];
  assign rx_flush = wr_ctrl & reg_wdata[C_RXFL];
  assign run      = ~ctl_q.halt;

  // control and enable registers: next state
  always_comb begin
    ctl_d = ctl_q;
    en_d  = en_q;
    if (wr_ctrl) begin
      ctl_d.halt   = reg_wdata[C_HALT];
      ctl_d.tx_off = reg_wdata[C_TXOFF];
      ctl_d.rx_off = reg_wdata[C_RXOFF];
      ctl_d.keep   = reg_wdata[C_KEEP];
    end
    if (wr_enab) en_d = reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '{halt: 1'b1, tx_off: 1'b0, rx_off: 1'b0, keep: 1'b0};
      en_q  <= '0;
    end else begin
      ctl_q <= ctl_d;
      en_q  <= en_d;
    end
  end

  // transmit side
  assign tx_pop = sh_pop & run;

  spi_fifo_store #(.W(DATA_W), .DEPTH(TX_DEPTH), .CW(TX_CW)) u_txq (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (tx_flush),
    .single(ctl_q.tx_off),
    .push  (host_tx_push),
    .wdata (host_tx_data),
    .pop   (tx_pop),
    .head  (sh_tx_data),
    .count (tx_cnt),
    .full  (tx_full),
    .empty (tx_empty)
  );

  // receive side
  assign sh_in       = sh_push & run;
  assign host_pop_ok = host_rx_pop & ~rx_empty;
  assign rx_over_evt = sh_in & rx_full & ~host_pop_ok;
  assign rx_drop_old = rx_over_evt & ctl_q.keep;
  assign rx_pop      = host_rx_pop | rx_drop_old;

  spi_fifo_store #(.W(DATA_W), .DEPTH(RX_DEPTH), .CW(RX_CW)) u_rxq (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (rx_flush),
    .single(ctl_q.rx_off),
    .push  (sh_in),
    .wdata (sh_rx_data),
    .pop   (rx_pop),
    .head  (host_rx_data),
    .count (rx_cnt),
    .full  (rx_full),
    .empty (rx_empty)
  );

  // sticky events
  always_comb begin
    ev_set          = '0;
    ev_set[S_DONE]  = sh_done & run;
    ev_set[S_EOQ]   = sh_done & sh_eoq & run;
    ev_set[S_UNDER] = tx_pop & tx_empty;
    ev_set[S_OVER]  = rx_over_evt;
    ev_clr          = '0;
    if (wr_stat) begin
      ev_clr[S_DONE]  = reg_wdata[B_DONE];
      ev_clr[S_EOQ]   = reg_wdata[B_EOQ];
      ev_clr[S_UNDER] = reg_wdata[B_UNDER];
      ev_clr[S_OVER]  = reg_wdata[B_OVER];
    end
  end

  spi_fifo_flags #(.N(NSTICKY)) u_flags (
    .clk  (clk),
    .rst_n(rst_n),
    .set  (ev_set),
    .clr  (ev_clr),
    .q    (sticky_q)
  );

  assign fill  = ~tx_full;
  assign drain = ~rx_empty;

  spi_fifo_route u_route (
    .sticky(sticky_q),
    .fill  (fill),
    .drain (drain),
    .en    (en_q),
    .irq   (irq),
    .dma_tx(dma_tx_req),
    .dma_rx(dma_rx_req)
  );

  assign sh_tx_valid = run & ~tx_empty;

  always_comb begin
    stat_word          = '0;
    stat_word[B_DONE]  = sticky_q[S_DONE];
    stat_word[B_EOQ]   = sticky_q[S_EOQ];
    stat_word[B_UNDER] = sticky_q[S_UNDER];
    stat_word[B_FILL]  = fill;
    stat_word[B_OVER]  = sticky_q[S_OVER];
    stat_word[B_DRAIN] = drain;
    stat_word[B_RUN]   = run;
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL: begin
        reg_rdata[C_HALT]  = ctl_q.halt;
        reg_rdata[C_TXOFF] = ctl_q.tx_off;
        reg_rdata[C_RXOFF] = ctl_q.rx_off;
        reg_rdata[C_KEEP]  = ctl_q.keep;
      end
      A_STAT:  reg_rdata = stat_word;
      A_ENAB:  reg_rdata = en_q;
      default: reg_rdata = {4'(rx_cnt), 4'(tx_cnt)};
    endcase
  end
endmodule

// File: rtl/spi_fifo_ctl_chk.sv
module spi_fifo_ctl_chk #(
  parameter int TX_DEPTH = 4,
  parameter int TX_CW    = 3,
  parameter int RX_CW    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [1:0]       reg_addr,
  input logic [7:0]       reg_wdata,
  input logic             sh_pop,
  input logic             sh_push,
  input logic             host_rx_pop,
  input logic             run,
  input logic             keep,
  input logic             rx_full,
  input logic [TX_CW-1:0] tx_cnt,
  input logic [RX_CW-1:0] rx_cnt,
  input logic [3:0]       sticky,
  input logic             sh_tx_valid,
  input logic             dma_tx_req
);
  // R6
  under_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_pop && run && tx_cnt == '0) |=> sticky[2]);

  // R2
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky[2] && !(reg_wr && reg_addr == 2'd1 && reg_wdata[2])) |=> sticky[2]);

  // R7
  keep_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (keep && rx_full && sh_push && run && !host_rx_pop &&
     !(reg_wr && reg_addr == 2'd0 && reg_wdata[4])) |=> $stable(rx_cnt));

  // R10
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !sh_tx_valid);

  // R5
  dma_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_tx_req |-> (tx_cnt < TX_CW'(TX_DEPTH)));

  // R12
  tx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= TX_CW'(TX_DEPTH));
endmodule

bind spi_fifo_ctl spi_fifo_ctl_chk #(
  .TX_DEPTH(TX_DEPTH),
  .TX_CW   (TX_CW),
  .RX_CW   (RX_CW)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_wr     (reg_wr),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .sh_pop     (sh_pop),
  .sh_push    (sh_push),
  .host_rx_pop(host_rx_pop),
  .run        (run),
  .keep       (ctl_q.keep),
  .rx_full    (rx_full),
  .tx_cnt     (tx_cnt),
  .rx_cnt     (rx_cnt),
  .sticky     (sticky_q),
  .sh_tx_valid(sh_tx_valid),
  .dma_tx_req (dma_tx_req)
);

// File: tb/spi_fifo_ctl_bench.sv
`timescale 1ns/1ps
module spi_fifo_ctl_bench;
  localparam int DW  = 16;
  localparam int TXD = 4;
  localparam int RXD = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd1;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic host_tx_push = 1'b0;
  logic [DW-1:0] host_tx_data = '0;
  logic host_rx_pop = 1'b0;
  logic [DW-1:0] host_rx_data;
  logic sh_pop = 1'b0;
  logic sh_tx_valid;
  logic [DW-1:0] sh_tx_data;
  logic sh_push = 1'b0;
  logic [DW-1:0] sh_rx_data = '0;
  logic sh_done = 1'b0;
  logic sh_eoq = 1'b0;
  logic irq, dma_tx_req, dma_rx_req;

  always #2 clk = ~clk;

  spi_fifo_ctl #(.DATA_W(DW), .TX_DEPTH(TXD), .RX_DEPTH(RXD)) u_spi_fifo_ctl (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .host_tx_push(host_tx_push), .host_tx_data(host_tx_data),
    .host_rx_pop(host_rx_pop), .host_rx_data(host_rx_data),
    .sh_pop(sh_pop), .sh_tx_valid(sh_tx_valid), .sh_tx_data(sh_tx_data),
    .sh_push(sh_push), .sh_rx_data(sh_rx_data),
    .sh_done(sh_done), .sh_eoq(sh_eoq),
    .irq(irq), .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  string ph = "R1";

  // reference model
  int   txq[$];
  int   rxq[$];
  bit   m_halt, m_txoff, m_rxoff, m_keep;
  bit [7:0] m_en;
  bit [3:0] m_st; // [0] done [1] eoq [2] starvation [3] overflow

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit m_fill();
    return txq.size() < (m_txoff ? 1 : TXD);
  endfunction

  function automatic bit m_drain();
    return rxq.size() > 0;
  endfunction

  function automatic logic [7:0] m_read(input logic [1:0] a);
    case (a)
      2'd0: return {2'b0, m_keep, 2'b0, m_rxoff, m_txoff, m_halt};
      2'd1: return {1'b0, !m_halt, m_drain(), m_st[3], m_fill(), m_st[2], m_st[1], m_st[0]};
      2'd2: return m_en;
      default: return {4'(rxq.size()), 4'(txq.size())};
    endcase
  endfunction

  task automatic compare();
    bit f, d, ei;
    f = m_fill();
    d = m_drain();
    ei = (m_st[0] & m_en[0]) | (m_st[1] & m_en[1]) | (m_st[2] & m_en[2]) |
         (f & m_en[3] & !m_en[6]) | (m_st[3] & m_en[4]) | (d & m_en[5] & !m_en[7]);
    chk(ph, reg_rdata, m_read(reg_addr));
    chk("R4", irq, ei);
    chk("R5", {dma_tx_req, dma_rx_req}, {f & m_en[3] & m_en[6], d & m_en[5] & m_en[7]});
    chk("R10", sh_tx_valid, !m_halt && txq.size() > 0);
    if (txq.size() > 0) chk("R12", sh_tx_data, txq[0]);
    if (rxq.size() > 0) chk("R12", host_rx_data, rxq[0]);
  endtask

  task automatic model_step();
    bit run, wc, ws, we, tpop, under, tpush, hpop, spush, rfull, over;
    bit [3:0] clr, set;
    int txcap, rxcap;
    run   = !m_halt;
    wc    = reg_wr && reg_addr == 2'd0;
    ws    = reg_wr && reg_addr == 2'd1;
    we    = reg_wr && reg_addr == 2'd2;
    txcap = m_txoff ? 1 : TXD;
    rxcap = m_rxoff ? 1 : RXD;
    tpop  = sh_pop && run && txq.size() > 0;
    under = sh_pop && run && txq.size() == 0;
    tpush = host_tx_push && (txq.size() < txcap || tpop);
    hpop  = host_rx_pop && rxq.size() > 0;
    spush = sh_push && run;
    rfull = rxq.size() >= rxcap;
    over  = spush && rfull && !hpop;
    if (wc && reg_wdata[3]) txq.delete();
    else begin
      if (tpop) void'(txq.pop_front());
      if (tpush) txq.push_back(int'(host_tx_data));
    end
    if (wc && reg_wdata[4]) rxq.delete();
    else begin
      if (hpop) void'(rxq.pop_front());
      if (spush) begin
        if (!rfull || hpop) rxq.push_back(int'(sh_rx_data));
        else if (m_keep) begin
          void'(rxq.pop_front());
          rxq.push_back(int'(sh_rx_data));
        end
      end
    end
    clr = ws ? {reg_wdata[4], reg_wdata[2], reg_wdata[1], reg_wdata[0]} : 4'b0;
    set = {over, under, sh_done && sh_eoq && run, sh_done && run};
    m_st = (m_st & ~clr) | set;
    if (wc) begin
      m_halt  = reg_wdata[0];
      m_txoff = reg_wdata[1];
      m_rxoff = reg_wdata[2];
      m_keep  = reg_wdata[5];
    end
    if (we) m_en = reg_wdata;
  endtask

  task automatic cyc();
    #1;
    compare();
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic idle();
    reg_wr = 0; reg_addr = 2'd1; reg_wdata = '0;
    host_tx_push = 0; host_rx_pop = 0; sh_pop = 0; sh_push = 0;
    sh_done = 0; sh_eoq = 0;
  endtask

  task automatic wreg(input logic [1:0] a, input logic [7:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    cyc();
    idle();
  endtask

  task automatic txpush(input logic [15:0] d);
    host_tx_push = 1; host_tx_data = d;
    cyc();
    idle();
  endtask

  task automatic rxin(input logic [15:0] d);
    sh_push = 1; sh_rx_data = d;
    cyc();
    idle();
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    m_halt = 1; m_txoff = 0; m_rxoff = 0; m_keep = 0; m_en = '0; m_st = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset values on every address
    ph = "R1";
    for (int a = 0; a < 4; a++) begin
      reg_addr = 2'(a);
      #1;
      chk("R1", reg_rdata, (a == 0) ? 8'h01 : (a == 1) ? 8'h08 : 8'h00);
      cyc();
    end
    idle();

    // R10: strobes ignored while halted
    ph = "R10";
    txpush(16'h1111);
    txpush(16'h2222);
    sh_pop = 1; sh_push = 1; sh_done = 1; sh_eoq = 1; sh_rx_data = 16'hdead;
    cyc();
    idle();
    reg_addr = 2'd3;
    #1; chk("R10", reg_rdata, 8'h02);
    cyc();
    wreg(2'd0, 8'h00);

    // R12: order, full queue, push with pop on full
    ph = "R12";
    txpush(16'h3333);
    txpush(16'h4444);
    // R3: TX now full, room bit clears
    ph = "R3";
    #1; chk("R3", reg_rdata[3], 1'b0);
    cyc();
    // R3: writes to bits 3, 5, 6 have no effect
    wreg(2'd1, 8'h68);
    ph = "R12";
    host_tx_push = 1; host_tx_data = 16'h5555; sh_pop = 1;
    cyc();
    idle();
    reg_addr = 2'd3;
    #1; chk("R12", reg_rdata, 8'h04);
    cyc();
    repeat (4) begin sh_pop = 1; cyc(); end
    idle();

    // R6: starvation; R2: clear with 0, clear with 1, set wins over clear
    ph = "R6";
    sh_pop = 1; cyc(); idle();
    ph = "R2";
    wreg(2'd1, 8'h00);
    reg_wr = 1; reg_addr = 2'd1; reg_wdata = 8'h04; sh_pop = 1;
    cyc();
    idle();
    #1; chk("R2", reg_rdata[2], 1'b1);
    cyc();
    wreg(2'd1, 8'h04);

    // R7: overflow in both modes
    ph = "R7";
    for (int i = 0; i < 5; i++) rxin(16'h0a00 + 16'(i));
    host_rx_pop = 1; sh_push = 1; sh_rx_data = 16'h0b00;
    cyc();
    idle();
    wreg(2'd0, 8'h20);
    rxin(16'h0c00);
    #1; chk("R7", host_rx_data, 16'h0a02);
    cyc();
    wreg(2'd1, 8'h10);

    // R9: flush with push in the same cycle; flush bits read back 0
    ph = "R9";
    reg_wr = 1; reg_addr = 2'd0; reg_wdata = 8'h18; sh_push = 1; sh_rx_data = 16'h0d00;
    cyc();
    idle();
    reg_addr = 2'd0;
    #1; chk("R9", reg_rdata, 8'h00);
    cyc();

    // R8: single-entry capacity
    ph = "R8";
    wreg(2'd0, 8'h06);
    txpush(16'h6666);
    txpush(16'h7777);
    rxin(16'h0e00);
    rxin(16'h0f00);
    reg_addr = 2'd3;
    #1; chk("R8", reg_rdata, 8'h11);
    cyc();
    wreg(2'd0, 8'h18);

    // R11: frame done with and without last-of-queue
    ph = "R11";
    sh_done = 1; cyc(); idle();
    sh_done = 1; sh_eoq = 1; cyc(); idle();
    wreg(2'd1, 8'h03);

    // R4 / R5: routing combinations
    ph = "R4";
    wreg(2'd2, 8'h3f);
    txpush(16'h8888);
    wreg(2'd2, 8'hff);
    wreg(2'd2, 8'h28);
    wreg(2'd2, 8'h00);

    // R13 and mixed traffic: random stress under all modes
    ph = "R13";
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = $urandom % 8;
      reg_wr = (r == 0);
      reg_addr = 2'($urandom % 4);
      reg_wdata = 8'($urandom);
      if (reg_addr == 2'd0) reg_wdata[0] = (($urandom % 8) == 0);
      host_tx_push = ($urandom % 3) == 0;
      host_tx_data = 16'($urandom);
      host_rx_pop = ($urandom % 3) == 0;
      sh_pop = ($urandom % 3) == 0;
      sh_push = ($urandom % 2) == 0;
      sh_rx_data = 16'($urandom);
      sh_done = ($urandom % 4) == 0;
      sh_eoq = ($urandom % 2) == 0;
      cyc();
    end
    idle();
    cyc();

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule